// File: doc/BRIEF.md
# Sliding-Window Occupancy Trigger

This block is a first-level trigger for a sampled photomultiplier pulse. Two digitizer channels deliver 10-bit unsigned samples at 40 MHz. One channel has eight times the gain of the other. A range select chooses which channel is used. Each accepted sample of that channel is compared against a programmable threshold, and the result is recorded in a bit history.

The block keeps a running count of above-threshold samples over the most recent programmable number of bins. When the count reaches the programmed need, it raises a one-cycle trigger. With the trigger it gives the running sample number of the bin that completed the condition, so readout logic can locate the surrounding samples in its buffer. A hold-off measured in clock cycles keeps the output rate down. A trigger counter lets software form a rate.

A typical setting is four bins above a level of 2 low-gain counts within a 240-bin window. The configuration inputs are expected to stay fixed while reset is released. They are changed only with reset asserted.

Top module: `sliding_tot_trigger`

## Requirements
- R1: A sample counts as above threshold only when the selected channel value is strictly greater than `threshold`. `rangeSel`=0 selects `sampleLo` and `rangeSel`=1 selects `sampleHi`. The unselected channel has no effect.
- R2: The window count is the number of above-threshold samples among the current sample and the previous `windowLen`-1 accepted samples. A `windowLen` of 0 behaves as 1.
- R3: On a clock edge with `sampleValid` high, `trigOut` is high for exactly the following cycle when three conditions hold: the updated window count is at least `needCount`, `needCount` is at least 1, and no hold-off is running.
- R4: With `needCount` equal to 0 the trigger never fires.
- R5: Accepted samples are numbered from 0 after reset. On a trigger, `trigStamp` shows the number of the sample that completed the condition, and it keeps that value until the next trigger.
- R6: After a trigger at some clock edge, no trigger occurs on the next `holdOff` clock edges. The condition is evaluated normally from the edge after those.
- R7: `trigCount` goes up by one with each trigger.
- R8: While reset is asserted, `trigOut`, `trigStamp` and `trigCount` are 0, and the history and window count are cleared.
- R9: A clock edge with `sampleValid` low never produces a trigger. It does not advance the window or the sample number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A new sample pair is present |
| sampleLo | input | 10 | Low-gain channel sample |
| sampleHi | input | 10 | High-gain channel sample |
| rangeSel | input | 1 | 0 compares the low-gain channel, 1 compares the high-gain channel |
| threshold | input | 10 | Compare level; the sample must exceed it |
| windowLen | input | 8 | Window length in bins (0 acts as 1) |
| needCount | input | 8 | Above-threshold bins needed to fire (0 disables) |
| holdOff | input | 16 | Clock cycles of suppression after a trigger |
| trigOut | output | 1 | One-cycle trigger pulse |
| trigStamp | output | 32 | Number of the sample that completed the last trigger |
| trigCount | output | 16 | Number of triggers since reset |

## Verification
A sample presented before a clock edge affects all three outputs one cycle later. At that edge `trigOut` rises for one cycle, `trigStamp` takes the completing sample's number, and `trigCount` steps. The bench drives each sample on the falling edge. It predicts the outputs for the coming rising edge from its own window sum and its own record of the last trigger cycle, and it compares them shortly after that rising edge. Hold-off is predicted by counting clock edges since the last trigger, so idle cycles inside the hold-off are counted as the requirement states.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // strobes sent from control to datapath each cycle
  typedef struct packed {
    logic advance;  // shift a new sample into the window
    logic capture;  // latch the current sample number as the trigger stamp
  } trigStrobe_t;
endpackage

// File: rtl/tot_datapath.sv
module tot_datapath
  import trig_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int WIN_W    = 8,
  parameter int STAMP_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  trigStrobe_t         strobe,
  input  logic [SAMPLE_W-1:0] sampleLo,
  input  logic [SAMPLE_W-1:0] sampleHi,
  input  logic                rangeSel,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [WIN_W-1:0]    windowLen,
  output logic [WIN_W-1:0]    winCountNext,
  output logic [STAMP_W-1:0]  trigStamp
);
  localparam int HIST_DEPTH = 1 << WIN_W;

  logic [HIST_DEPTH-1:0] history;
  logic [WIN_W-1:0]      winCount;
  logic [STAMP_W-1:0]    stamp;
  logic [WIN_W-1:0]      effLen;
  logic [SAMPLE_W-1:0]   selSample;
  logic                  above;
  logic                  leaving;

  always_comb begin
    effLen       = (windowLen == '0) ? WIN_W'(1) : windowLen;
    selSample    = rangeSel ? sampleHi : sampleLo;
    above        = selSample > threshold;
    leaving      = history[effLen - WIN_W'(1)];
    winCountNext = winCount + WIN_W'(above) - WIN_W'(leaving);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      history   <= '0;
      winCount  <= '0;
      stamp     <= '0;
      trigStamp <= '0;
    end else begin
      if (strobe.advance) begin
        history  <= {history[HIST_DEPTH-2:0], above};
        winCount <= winCountNext;
        stamp    <= stamp + STAMP_W'(1);
      end
      if (strobe.capture) trigStamp <= stamp;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    winCount <= effLen); // R2

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> ($stable(winCount) && $stable(stamp))); // R9
endmodule

// File: rtl/tot_control.sv
module tot_control
  import trig_pkg::*;
#(
  parameter int WIN_W  = 8,
  parameter int HOLD_W = 16,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [WIN_W-1:0]  needCount,
  input  logic [HOLD_W-1:0] holdOff,
  input  logic [WIN_W-1:0]  winCountNext,
  output trigStrobe_t       strobe,
  output logic              trigOut,
  output logic [RATE_W-1:0] trigCount
);
  logic [HOLD_W-1:0] holdCnt;
  logic              fire;

  always_comb begin
    fire = sampleValid && (needCount != '0) && (winCountNext >= needCount)
           && (holdCnt == '0);
    strobe.advance = sampleValid;
    strobe.capture = fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt   <= '0;
      trigOut   <= 1'b0;
      trigCount <= '0;
    end else begin
      trigOut <= fire;
      if (fire) begin
        trigCount <= trigCount + RATE_W'(1);
        holdCnt   <= holdOff;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - HOLD_W'(1);
      end
    end
  end

  AST_HOLDOFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (holdCnt != '0) |=> !trigOut); // R6

  AST_ZERO_NEED: assert property (@(posedge clk) disable iff (!rstN)
    (needCount == '0) |=> !trigOut); // R4

  AST_IDLE_NO_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !trigOut); // R9

  AST_FIRE_COND: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> ($past(winCountNext) >= $past(needCount))); // R3

  AST_RATE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> (trigCount == $past(trigCount) + RATE_W'(1))); // R7
endmodule

// File: rtl/sliding_tot_trigger.sv
module sliding_tot_trigger
  import trig_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int WIN_W    = 8,
  parameter int STAMP_W  = 32,
  parameter int HOLD_W   = 16,
  parameter int RATE_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleLo,
  input  logic [SAMPLE_W-1:0] sampleHi,
  input  logic                rangeSel,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [WIN_W-1:0]    windowLen,
  input  logic [WIN_W-1:0]    needCount,
  input  logic [HOLD_W-1:0]   holdOff,
  output logic                trigOut,
  output logic [STAMP_W-1:0]  trigStamp,
  output logic [RATE_W-1:0]   trigCount
);
  trigStrobe_t      strobe;
  logic [WIN_W-1:0] winCountNext;

  tot_datapath #(
    .SAMPLE_W(SAMPLE_W), .WIN_W(WIN_W), .STAMP_W(STAMP_W)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleLo(sampleLo), .sampleHi(sampleHi), .rangeSel(rangeSel),
    .threshold(threshold), .windowLen(windowLen),
    .winCountNext(winCountNext), .trigStamp(trigStamp)
  );

  tot_control #(
    .WIN_W(WIN_W), .HOLD_W(HOLD_W), .RATE_W(RATE_W)
  ) uControl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .needCount(needCount), .holdOff(holdOff), .winCountNext(winCountNext),
    .strobe(strobe), .trigOut(trigOut), .trigCount(trigCount)
  );
endmodule

// File: tb/sim_sliding_tot_trigger.sv
`timescale 1ns/1ps
module sim_sliding_tot_trigger;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [9:0]  sampleLo = '0;
  logic [9:0]  sampleHi = '0;
  logic        rangeSel = 1'b0;
  logic [9:0]  threshold = '0;
  logic [7:0]  windowLen = 8'd1;
  logic [7:0]  needCount = 8'd1;
  logic [15:0] holdOff = '0;
  logic        trigOut;
  logic [31:0] trigStamp;
  logic [15:0] trigCount;

  sliding_tot_trigger u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleLo(sampleLo), .sampleHi(sampleHi), .rangeSel(rangeSel),
    .threshold(threshold), .windowLen(windowLen), .needCount(needCount),
    .holdOff(holdOff), .trigOut(trigOut), .trigStamp(trigStamp),
    .trigCount(trigCount)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  bit          histM [0:255];
  int unsigned sampleIdx;
  longint      cyc = 0;
  longint      lastTrig;
  logic        expTrig;
  logic [31:0] expStamp;
  logic [15:0] expCnt;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int effWin(logic [7:0] wl);
    return (wl == 0) ? 1 : int'(wl);
  endfunction

  function automatic int windowSum(int len);
    int s = 0;
    for (int i = 0; i < len; i++) s += histM[i];
    return s;
  endfunction

  task automatic setup(logic rs, logic [9:0] th, logic [7:0] wl, logic [7:0] nc,
                       logic [15:0] ho);
    @(negedge clk);
    rstN = 1'b0;
    sampleValid = 1'b0;
    rangeSel = rs; threshold = th; windowLen = wl; needCount = nc; holdOff = ho;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #0.5;
    // R8: outputs cleared while in reset
    chk("R8", "trigOut", 32'(trigOut), 0);
    chk("R8", "trigStamp", trigStamp, 0);
    chk("R8", "trigCount", 32'(trigCount), 0);
    rstN = 1'b1;
    for (int i = 0; i < 256; i++) histM[i] = 1'b0;
    sampleIdx = 0;
    lastTrig = -1000000;
    expTrig = 1'b0; expStamp = '0; expCnt = '0;
  endtask

  task automatic doCycle(logic v, logic [9:0] lo, logic [9:0] hi, string tag);
    logic [9:0] sel;
    int cnt;
    @(negedge clk);
    sampleValid = v; sampleLo = lo; sampleHi = hi;
    expTrig = 1'b0;
    if (v) begin
      sel = rangeSel ? hi : lo;
      for (int i = 255; i > 0; i--) histM[i] = histM[i-1];
      histM[0] = (sel > threshold);
      cnt = windowSum(effWin(windowLen));
      if (needCount != 0 && cnt >= int'(needCount) && (cyc - lastTrig > longint'(holdOff))) begin
        expTrig = 1'b1;
        expStamp = sampleIdx;
        expCnt = expCnt + 16'd1;
        lastTrig = cyc;
      end
      sampleIdx++;
    end
    cyc++;
    @(posedge clk);
    #1;
    chk(tag, "trigOut", 32'(trigOut), 32'(expTrig));
    chk("R5", "trigStamp", trigStamp, expStamp);
    chk("R7", "trigCount", 32'(trigCount), 32'(expCnt));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));

    // R1: strict compare on low gain, high gain ignored; R2: sample leaves the window
    setup(1'b0, 10'd2, 8'd4, 8'd2, 16'd0);
    doCycle(1, 10'd3, 10'd1023, "R1");
    doCycle(1, 10'd2, 10'd1023, "R1");  // equal to threshold: not above
    doCycle(1, 10'd0, 10'd1023, "R1");
    doCycle(1, 10'd0, 10'd1023, "R2");
    doCycle(1, 10'd5, 10'd1023, "R2");  // first sample has left: count 1
    doCycle(1, 10'd7, 10'd1023, "R3");  // count 2: fires
    doCycle(1, 10'd9, 10'd0,    "R3");  // still 3 in window: fires again

    // R1: high-gain range selected
    setup(1'b1, 10'd2, 8'd4, 8'd2, 16'd0);
    doCycle(1, 10'd1023, 10'd3, "R1");
    doCycle(1, 10'd1023, 10'd1, "R1");
    doCycle(1, 10'd1023, 10'd4, "R1");

    // R4: need of zero disables
    setup(1'b0, 10'd2, 8'd4, 8'd0, 16'd0);
    for (int i = 0; i < 10; i++) doCycle(1, 10'd1023, 10'd1023, "R4");

    // R2: window length 0 acts as 1
    setup(1'b0, 10'd2, 8'd0, 8'd1, 16'd0);
    doCycle(1, 10'd3, 10'd0, "R2");
    doCycle(1, 10'd0, 10'd0, "R2");
    doCycle(1, 10'd3, 10'd0, "R2");

    // R6: hold-off with continuous above-threshold samples and gaps
    setup(1'b0, 10'd2, 8'd8, 8'd1, 16'd5);
    for (int i = 0; i < 30; i++) doCycle((i % 7) != 3, 10'd3, 10'd0, "R6");

    // R9: idle edges never trigger and do not advance
    setup(1'b0, 10'd0, 8'd4, 8'd1, 16'd0);
    doCycle(1, 10'd1, 10'd0, "R3");
    for (int i = 0; i < 5; i++) doCycle(0, 10'd1, 10'd1, "R9");
    doCycle(1, 10'd0, 10'd0, "R9");

    // random rounds, first one with the typical 240-bin/4-bin setting
    for (int r = 0; r < 6; r++) begin
      logic [7:0] wl;
      logic [7:0] nc;
      if (r == 0) begin
        wl = 8'd240; nc = 8'd4;
        setup(1'b0, 10'd2, wl, nc, 16'd20);
      end else begin
        wl = 8'($urandom_range(1, 255));
        nc = 8'($urandom_range(1, 6));
        setup(1'($urandom_range(0, 1)), 10'($urandom_range(0, 3)), wl, nc,
              16'($urandom_range(0, 40)));
      end
      for (int i = 0; i < 2000; i++) begin
        logic v;
        logic [9:0] lo;
        logic [9:0] hi;
        v  = ($urandom % 4) != 0;
        lo = (($urandom % 8) == 0) ? 10'($urandom % 1024) : 10'($urandom % 4);
        hi = (($urandom % 8) == 0) ? 10'($urandom % 1024) : 10'($urandom % 4);
        doCycle(v, lo, hi, "R3");
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule